// File: doc/BRIEF.md
# Per-Channel Header Field Persistence Acceptor

This block sits after a packet header parser on the receive side of a channelised packet path. For every received packet it is handed a strobe, the channel number, one overhead field taken from the header and that header's parity bit. For each channel it keeps the accepted field value. That value changes only when a new value has turned up in a configurable number of consecutive packets on that channel. The accepted values of all channels are presented side by side on one status vector.

Each packet produces at most a few one-cycle pulses. An acceptance pulse means a channel took on a new value. An inconsistency pulse means a packet's value disagreed with the value accepted at that moment. A parity pulse means the header failed its odd-parity check. A parity failure also advances a saturating error counter. A packet with a parity failure is treated as not received for filtering purposes. The channel that produced the pulses is reported next to them.

Each channel runs a two-state machine. In `ST_HOLD` the candidate equals the accepted value. Transition *hold→track*: a good packet carries a value other than the accepted one and the threshold is above 1. In `ST_TRACK` a run of a candidate differing from the accepted value is being counted. Transition *track→hold (adopt)*: the run reaches the threshold and the candidate becomes accepted. Transition *track→hold (revert)*: a good packet carries the accepted value again. Transition *track→track (restart)*: a good packet carries a third value, which becomes the candidate with a count of 1. With a threshold of 1, a differing value is adopted directly in `ST_HOLD`.

Top module: `sar_oh_acceptor`

## Requirements
- R1: On a channel, a value V different from the accepted value is adopted after the threshold number of consecutive good-parity packets carrying V. The threshold is `cfg_persist`, with 0 treated as 1. The new value shows in `acc_values[ch*FIELD_W +: FIELD_W]` one cycle after the packet that completes the run.
- R2: `acc_evt` is high for exactly one cycle, one cycle after a packet that causes an adoption. With it, `evt_ch` gives that packet's channel. A good packet carrying the already accepted value never raises `acc_evt`.
- R3: A good packet whose value differs from the current candidate restarts the run. That value becomes the candidate with a count of 1.
- R4: `inc_evt` pulses one cycle after every good-parity packet whose value differs from the value accepted when it arrived. This includes the packet that causes an adoption, so both pulses appear in the same cycle.
- R5: A header is good when the number of ones in {`pkt_field`, `pkt_par`} is odd. A bad header raises `par_evt` one cycle later. It also adds 1 to `par_err_cnt`, which holds at its all-ones maximum.
- R6: A bad-parity packet leaves the candidate, the count and the accepted value unchanged, and it raises neither `acc_evt` nor `inc_evt`.
- R7: After reset, all accepted values, the candidates, the counts and `par_err_cnt` are zero, and no pulse is raised. A good packet carrying 0 then raises nothing.
- R8: Channels are independent. Packets on one channel neither advance nor break the run on another channel.
- R9: A cycle with `pkt_vld` low changes no state and raises no pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_persist | input | PW (4) | Consecutive-packet threshold; 0 acts as 1 |
| pkt_vld | input | 1 | One received header per cycle when high |
| pkt_ch | input | CH_W (3) | Channel of the header |
| pkt_field | input | FIELD_W (8) | Overhead field value |
| pkt_par | input | 1 | Header parity bit (odd parity with the field) |
| acc_values | output | NUM_CH*FIELD_W (64) | Accepted value per channel, channel c at bits c*FIELD_W upward |
| acc_evt | output | 1 | Adoption pulse |
| inc_evt | output | 1 | Inconsistency pulse |
| par_evt | output | 1 | Parity failure pulse |
| evt_ch | output | CH_W (3) | Channel of the last valid header, qualifying the pulses |
| par_err_cnt | output | CNT_W (16) | Saturating parity error count |

## Verification
The adoption pulse and the inconsistency pulse fall in the same cycle: the packet that completes a run still disagrees with the old accepted value. A parity failure must suppress both. Directed runs force the coincidence with thresholds of 1, 3 and 5, and place a bad-parity copy in the middle of a run. Random traffic uses a small value alphabet so that runs, restarts and reversions happen often. A reference model in the bench predicts all three pulses for each packet, and each pulse is compared on its own in the cycle after the packet.

// File: rtl/sar_oh_pkg.sv
package sar_oh_pkg;

    typedef enum logic {
        ST_HOLD  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;

endpackage

// File: rtl/oh_parity_chk.sv
module oh_parity_chk #(
    parameter int W = 8
) (
    input  logic [W-1:0] field,
    input  logic         par,
    output logic         good
);
    // odd parity: total number of ones across field and parity bit is odd
    always_comb begin
        good = ^{field, par};
    end
endmodule

// File: rtl/oh_sat_cnt.sv
module oh_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != MAXV) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R5
    sat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt_q == $past(cnt_q) + 1'b1) || ($past(cnt_q) == MAXV && cnt_q == MAXV));

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/oh_persist_trk.sv
module oh_persist_trk
    import sar_oh_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int PW      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,      // good-parity packet for this channel
    input  logic [FIELD_W-1:0] field,
    input  logic [PW-1:0]      n_eff,    // threshold, never zero
    output logic [FIELD_W-1:0] acc_o,
    output logic               acc_hit,
    output logic               inc_hit
);
    localparam logic [PW-1:0] CNT_MAX = {PW{1'b1}};
    localparam logic [PW-1:0] ONE     = {{(PW-1){1'b0}}, 1'b1};

    trk_state_e         state_q, state_n;
    logic [FIELD_W-1:0] cand_q, cand_n;
    logic [FIELD_W-1:0] acc_q, acc_n;
    logic [PW-1:0]      cnt_q, cnt_n;
    logic [PW-1:0]      cnt_inc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cand_q  <= '0;
            acc_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cand_q  <= cand_n;
            acc_q   <= acc_n;
            cnt_q   <= cnt_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n = state_q;
        cand_n  = cand_q;
        acc_n   = acc_q;
        cnt_n   = cnt_q;
        acc_hit = 1'b0;
        inc_hit = 1'b0;
        cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        if (sel) begin
            inc_hit = (field != acc_q);
            unique case (state_q)
                ST_HOLD: begin
                    if (field != acc_q) begin
                        cand_n = field;
                        cnt_n  = ONE;
                        if (n_eff <= ONE) begin
                            acc_n   = field;
                            acc_hit = 1'b1;
                        end else begin
                            state_n = ST_TRACK;
                        end
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                ST_TRACK: begin
                    if (field == acc_q) begin
                        // revert
                        cand_n  = field;
                        cnt_n   = ONE;
                        state_n = ST_HOLD;
                    end else if (field == cand_q) begin
                        cnt_n = cnt_inc;
                        if (cnt_inc >= n_eff) begin
                            // adopt
                            acc_n   = field;
                            acc_hit = 1'b1;
                            state_n = ST_HOLD;
                        end
                    end else begin
                        // restart
                        cand_n = field;
                        cnt_n  = ONE;
                        if (n_eff <= ONE) begin
                            acc_n   = field;
                            acc_hit = 1'b1;
                            state_n = ST_HOLD;
                        end
                    end
                end
                default: state_n = ST_HOLD;
            endcase
        end
    end

    assign acc_o = acc_q;

    // R1
    hold_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cand_q == acc_q));

    // R3
    track_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK) |-> (cand_q != acc_q && cnt_q != '0));

    // R6
    acc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_q) |-> $past(sel));

    // R9
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(acc_q) && $stable(cand_q) && $stable(state_q)));
endmodule

// File: rtl/sar_oh_acceptor.sv
module sar_oh_acceptor #(
    parameter int NUM_CH  = 8,
    parameter int FIELD_W = 8,
    parameter int PW      = 4,
    parameter int CNT_W   = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PW-1:0]             cfg_persist,
    input  logic                      pkt_vld,
    input  logic [CH_W-1:0]           pkt_ch,
    input  logic [FIELD_W-1:0]        pkt_field,
    input  logic                      pkt_par,
    output logic [NUM_CH*FIELD_W-1:0] acc_values,
    output logic                      acc_evt,
    output logic                      inc_evt,
    output logic                      par_evt,
    output logic [CH_W-1:0]           evt_ch,
    output logic [CNT_W-1:0]          par_err_cnt
);
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    logic              par_good;
    logic              par_bad;
    logic [PW-1:0]     n_eff;
    logic [NUM_CH-1:0] acc_hit_v;
    logic [NUM_CH-1:0] inc_hit_v;
    logic              acc_q, inc_q, par_q;
    logic [CH_W-1:0]   ch_q;

    oh_parity_chk #(.W(FIELD_W)) u_par (
        .field (pkt_field),
        .par   (pkt_par),
        .good  (par_good)
    );

    assign par_bad = pkt_vld && !par_good;
    assign n_eff   = (cfg_persist == '0) ? ONE : cfg_persist;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_c;
        assign sel_c = pkt_vld && par_good && (pkt_ch == CH_W'(c));
        oh_persist_trk #(.FIELD_W(FIELD_W), .PW(PW)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel_c),
            .field   (pkt_field),
            .n_eff   (n_eff),
            .acc_o   (acc_values[c*FIELD_W +: FIELD_W]),
            .acc_hit (acc_hit_v[c]),
            .inc_hit (inc_hit_v[c])
        );
    end

    oh_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (par_bad),
        .cnt   (par_err_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            inc_q <= 1'b0;
            par_q <= 1'b0;
            ch_q  <= '0;
        end else begin
            acc_q <= |acc_hit_v;
            inc_q <= |inc_hit_v;
            par_q <= par_bad;
            if (pkt_vld) begin
                ch_q <= pkt_ch;
            end
        end
    end

    assign acc_evt = acc_q;
    assign inc_evt = inc_q;
    assign par_evt = par_q;
    assign evt_ch  = ch_q;

    // R8
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_hit_v) && $onehot0(inc_hit_v));

    // R6
    par_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_evt |-> (!acc_evt && !inc_evt));

    // R4
    acc_with_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_evt |-> inc_evt);

    // R9
    no_pkt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_vld |=> (!acc_evt && !inc_evt && !par_evt && $stable(acc_values)));
endmodule

// File: tb/tb_sar_oh_acceptor.sv
module tb_sar_oh_acceptor;
    localparam int NCH = 8;
    localparam int FW  = 8;
    localparam int PW  = 4;
    localparam int CW  = 4;
    localparam int CHW = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [PW-1:0]     cfg_persist;
    logic              pkt_vld;
    logic [CHW-1:0]    pkt_ch;
    logic [FW-1:0]     pkt_field;
    logic              pkt_par;
    logic [NCH*FW-1:0] acc_values;
    logic              acc_evt, inc_evt, par_evt;
    logic [CHW-1:0]    evt_ch;
    logic [CW-1:0]     par_err_cnt;

    always #2 clk = ~clk;

    sar_oh_acceptor #(.NUM_CH(NCH), .FIELD_W(FW), .PW(PW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_persist(cfg_persist),
        .pkt_vld(pkt_vld), .pkt_ch(pkt_ch), .pkt_field(pkt_field), .pkt_par(pkt_par),
        .acc_values(acc_values), .acc_evt(acc_evt), .inc_evt(inc_evt), .par_evt(par_evt),
        .evt_ch(evt_ch), .par_err_cnt(par_err_cnt)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [FW-1:0] m_acc  [NCH];
    logic [FW-1:0] m_cand [NCH];
    int            m_run  [NCH];
    int            m_perr;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic mkpar(input logic [FW-1:0] v, input bit good);
        return good ? ~(^v) : (^v);
    endfunction

    function automatic int thr(input logic [PW-1:0] c);
        return (c == 0) ? 1 : int'(c);
    endfunction

    function automatic logic [NCH*FW-1:0] pack_acc();
        logic [NCH*FW-1:0] r;
        for (int c = 0; c < NCH; c++) r[c*FW +: FW] = m_acc[c];
        return r;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_acc[c] = '0; m_cand[c] = '0; m_run[c] = 0;
        end
        m_perr = 0;
    endtask

    // one packet; inputs set at negedge, outputs checked at the next negedge
    task automatic send(input int ch, input logic [FW-1:0] v, input bit good);
        bit e_acc, e_inc, e_par;
        @(negedge clk);
        pkt_vld = 1'b1; pkt_ch = CHW'(ch); pkt_field = v; pkt_par = mkpar(v, good);
        e_acc = 0; e_inc = 0; e_par = 0;
        if (!good) begin
            e_par = 1;
            if (m_perr < (1 << CW) - 1) m_perr++;
        end else begin
            e_inc = (v != m_acc[ch]);
            if (v == m_cand[ch]) begin
                if (m_run[ch] < 15) m_run[ch]++;
            end else begin
                m_cand[ch] = v; m_run[ch] = 1;
            end
            if (m_run[ch] >= thr(cfg_persist) && v != m_acc[ch]) begin
                m_acc[ch] = v; e_acc = 1;
            end
        end
        @(negedge clk);
        pkt_vld = 1'b0;
        chk(acc_evt == e_acc, "R2 acc_evt", acc_evt, e_acc);
        chk(inc_evt == e_inc, "R4 inc_evt", inc_evt, e_inc);
        chk(par_evt == e_par, "R5 par_evt", par_evt, e_par);
        chk(evt_ch == CHW'(ch), "R2 evt_ch", evt_ch, ch);
        chk(acc_values == pack_acc(), "R1 acc_values", acc_values, pack_acc());
        chk(par_err_cnt == CW'(m_perr), "R5 par_err_cnt", par_err_cnt, m_perr);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pkt_vld = 1'b0; pkt_field = 8'hFF; pkt_par = 1'b0;
            @(negedge clk);
            chk(!acc_evt && !inc_evt && !par_evt, "R9 idle pulses", {acc_evt, inc_evt, par_evt}, 0);
            chk(acc_values == pack_acc(), "R9 idle values", acc_values, pack_acc());
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_persist = 4'd3; pkt_vld = 1'b0;
        pkt_ch = '0; pkt_field = '0; pkt_par = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk(acc_values == '0, "R7 acc reset", acc_values, 0);
        chk(par_err_cnt == '0, "R7 cnt reset", par_err_cnt, 0);
        chk(!acc_evt && !inc_evt && !par_evt, "R7 no pulse", {acc_evt, inc_evt, par_evt}, 0);
        send(0, 8'h00, 1);                 // R7 zero value raises nothing

        // R1 threshold 3, adoption and inconsistency coincide (R4)
        send(2, 8'hA5, 1); send(2, 8'hA5, 1); send(2, 8'hA5, 1);
        send(2, 8'hA5, 1);                 // R2 repeat of accepted: no event
        // R3 restart
        send(2, 8'h11, 1); send(2, 8'h22, 1); send(2, 8'h11, 1);
        send(2, 8'h11, 1); send(2, 8'h11, 1);
        // R6 bad parity inside a run
        send(3, 8'h3C, 1); send(3, 8'h3C, 0); send(3, 8'h3C, 1); send(3, 8'h3C, 1);
        // R8 interleaved channels
        send(4, 8'h44, 1); send(5, 8'h55, 1); send(4, 8'h44, 1);
        send(5, 8'h55, 1); send(4, 8'h44, 1); send(5, 8'h55, 1);
        idle(3);
        // threshold 1 and 0
        cfg_persist = 4'd1; send(6, 8'h66, 1);
        cfg_persist = 4'd0; send(6, 8'h67, 1);
        // threshold 5 with revert
        cfg_persist = 4'd5;
        send(7, 8'h70, 1); send(7, 8'h70, 1); send(7, 8'h00, 1);
        for (int i = 0; i < 5; i++) send(7, 8'h71, 1);

        // constrained random traffic
        for (int blk = 0; blk < 40; blk++) begin
            cfg_persist = PW'(($urandom % 5) + 1);
            for (int i = 0; i < 80; i++) begin
                if (($urandom % 6) == 0) idle(1);
                else send(int'($urandom % NCH), FW'($urandom % 3),
                          ($urandom % 8) != 0);
            end
        end

        // R5 saturation of the error count
        for (int i = 0; i < 20; i++) send(1, 8'h5A, 0);
        chk(par_err_cnt == {CW{1'b1}}, "R5 saturated", par_err_cnt, {CW{1'b1}});

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule